// File: doc/BRIEF.md
# SD Data Timeout Counter

This block guards the data phase of an SD host against a card that stops responding. While a data phase is in progress it counts card clock cycles, marked by a one-cycle enable strobe in the host clock domain. Any sign of data-line activity resets the count. When the count reaches a power-of-two limit with no activity in between, the block sets a sticky data-timeout status bit. Software clears that bit by writing a one to it.

The limit is chosen by a 4-bit code held in bits 19:16 of the control word. The limit is 2^(code + BASE_EXP) card clock cycles. BASE_EXP defaults to 13, so the shortest window is 2^13 cycles and the longest usable window is 2^27 cycles. Code 14 is the largest usable value and is also the reset value. A written 15 is stored as 14.

Top module: `sdto_watchdog`

## Requirements
- R1: After reset the status flag is low and the stored code is 14, so an unprogrammed block times out after exactly 2^(14+BASE_EXP) strobes.
- R2: During an active data phase with no activity, the flag rises on the clock edge that carries the 2^(code+BASE_EXP)-th strobe counted from zero, and not on any earlier edge.
- R3: On a cycle with the control write strobe high, the code is taken from bits 19:16 of the control word. All other bits of that word have no effect on the limit.
- R4: A written code of 15 behaves exactly as 14.
- R5: The count advances only on cycles where the card clock enable strobe is high. Cycles without the strobe leave the time to expiry unchanged.
- R6: A data-activity pulse restarts the count from zero, even when it coincides with a strobe.
- R7: While no data phase is active, the count is held at zero and no timeout is flagged. Every new data phase starts counting from zero.
- R8: Once set, the flag stays high until the clear input is asserted. With no new expiry, it reads low on the next cycle after the clear.
- R9: If an expiry and a clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous reset, active low |
| card_clk_en | input | 1 | One-cycle strobe for each card clock cycle |
| data_phase | input | 1 | High while a data transfer is in progress |
| data_activity | input | 1 | Pulse marking activity on the data lines |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | CTRL_W (32) | Control word; the timeout code sits in bits 19:16 |
| dto_clr | input | 1 | Write-one-to-clear for the data timeout flag |
| dto_flag | output | 1 | Sticky data timeout status |

## Verification
The hardest case to reach is the longest window. With code 14, or a clamped 15, and the default base, an expiry takes 2^27 strobes. That is far too long to run through while also proving the exact edge of the expiry and showing that 15 is not stored as a longer window. The bench therefore builds the block with BASE_EXP set to 1. This keeps the real clamp and field decoding, and brings the longest window down to 32768 strobes. The bench checks the flag one strobe before and exactly at the limit, both for the reset default and for written codes of 14 and 15. Sparse strobe spacing and activity that coincides with a strobe are driven by directed steps.

// File: rtl/sdto_pkg.sv
// Shared constants and helpers for the SD data timeout counter.
// Assumes the code field is 4 bits wide and clamps at 14.
package sdto_pkg;
    localparam int CODE_W    = 4;
    localparam int MAX_CODE  = 14;
    localparam int FIELD_LSB = 16;

    typedef logic [CODE_W-1:0] tmo_code_t;

    // Clamp a raw field value to the largest usable code.
    function automatic tmo_code_t clamp_code(input tmo_code_t raw);
        return (raw > tmo_code_t'(MAX_CODE)) ? tmo_code_t'(MAX_CODE) : raw;
    endfunction
endpackage

// File: rtl/sdto_code_reg.sv
// Holds the timeout code. It captures the field on a write and clamps
// it to the largest usable value. Reset loads the largest code.
// Assumes the field slice has already been taken from the control word.
module sdto_code_reg
    import sdto_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  tmo_code_t field,
    output tmo_code_t code
);
    tmo_code_t code_q;

    // Capture the clamped code on a write; reset to the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= tmo_code_t'(MAX_CODE);
        else if (wr)
            code_q <= clamp_code(field);
    end

    assign code = code_q;
endmodule

// File: rtl/sdto_span_counter.sv
// Counts card clock strobes during a data phase. It restarts on
// activity and is held at zero outside a phase. It pulses expire on
// the strobe that completes 2^(code+BASE_EXP) cycles, then wraps to zero.
// Assumes code never exceeds MAX_CODE (the code register enforces this).
module sdto_span_counter
    import sdto_pkg::*;
#(
    parameter int BASE_EXP = 13,
    parameter int CNT_W    = BASE_EXP + MAX_CODE
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      phase,
    input  logic      activity,
    input  tmo_code_t code,
    output logic      expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   terminal;
    logic             at_end;

    // Window length and the last count value inside it.
    always_comb begin
        span     = {{CNT_W{1'b0}}, 1'b1} << (int'(code) + BASE_EXP);
        terminal = span - 1'b1;
        at_end   = ({1'b0, cnt_q} >= terminal);
        expire   = phase & ~activity & tick & at_end;
    end

    // Advance on strobes; restart on activity or outside a phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!phase || activity)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/sdto_sticky_flag.sv
// Write-one-to-clear status bit. When set and clear arrive together,
// set wins. Assumes set is a single-cycle pulse.
module sdto_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    // Hold the flag until cleared; a new set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/sdto_watchdog.sv
// Top of the SD data timeout counter. It decodes the code field from
// the control word and instantiates the code register, the span
// counter and the sticky flag. Assumes every input is synchronous to clk.
module sdto_watchdog
    import sdto_pkg::*;
#(
    parameter int CTRL_W   = 32,
    parameter int BASE_EXP = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_clk_en,
    input  logic              data_phase,
    input  logic              data_activity,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              dto_clr,
    output logic              dto_flag
);
    localparam int CNT_W = BASE_EXP + MAX_CODE;

    tmo_code_t code_field;
    tmo_code_t code;
    logic      expire;
    logic      ctrl_unused_bits;

    assign code_field       = ctrl_wdata[FIELD_LSB +: CODE_W];
    assign ctrl_unused_bits = ^{ctrl_wdata[CTRL_W-1:FIELD_LSB+CODE_W],
                                ctrl_wdata[FIELD_LSB-1:0]};

    sdto_code_reg u_code (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .field (code_field),
        .code  (code)
    );

    sdto_span_counter #(
        .BASE_EXP (BASE_EXP),
        .CNT_W    (CNT_W)
    ) u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (card_clk_en),
        .phase    (data_phase),
        .activity (data_activity),
        .code     (code),
        .expire   (expire)
    );

    sdto_sticky_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .clr   (dto_clr),
        .flag  (dto_flag)
    );
endmodule

// File: rtl/sdto_watchdog_chk.sv
// Property checker for sdto_watchdog. It is bound to every instance.
module sdto_watchdog_chk
    import sdto_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      card_clk_en,
    input logic      data_phase,
    input logic      data_activity,
    input logic      dto_clr,
    input logic      dto_flag,
    input logic      expire,
    input tmo_code_t code
);
    p_code_clamped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        code <= tmo_code_t'(MAX_CODE));

    p_expire_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> card_clk_en);

    p_no_expire_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (data_phase && !data_activity));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dto_flag && !dto_clr) |=> dto_flag);

    p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dto_clr && !expire) |=> !dto_flag);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> dto_flag);
endmodule

bind sdto_watchdog sdto_watchdog_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .card_clk_en   (card_clk_en),
    .data_phase    (data_phase),
    .data_activity (data_activity),
    .dto_clr       (dto_clr),
    .dto_flag      (dto_flag),
    .expire        (expire),
    .code          (code)
);

// File: tb/sdto_watchdog_tb.sv
// Self-checking bench for sdto_watchdog, built with BASE_EXP = 1.
module sdto_watchdog_tb;
    localparam int BASE = 1;
    localparam int NV   = 6;
    localparam logic [31:0] VEC_WORD [NV] = '{32'hFFF0_FFFF, 32'h0001_0000,
        32'h0003_0000, 32'h0005_A5A5, 32'h000E_0000, 32'h000F_0000};
    localparam int VEC_LIM [NV] = '{2, 4, 16, 64, 32768, 32768};
    localparam int VEC_GAP [NV] = '{0, 1, 0, 2, 0, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_clk_en = 1'b0;
    logic        data_phase = 1'b0;
    logic        data_activity = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        dto_clr = 1'b0;
    logic        dto_flag;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sdto_watchdog #(.CTRL_W(32), .BASE_EXP(BASE)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .card_clk_en   (card_clk_en),
        .data_phase    (data_phase),
        .data_activity (data_activity),
        .ctrl_wr       (ctrl_wr),
        .ctrl_wdata    (ctrl_wdata),
        .dto_clr       (dto_clr),
        .dto_flag      (dto_flag)
    );

    function automatic string vec_req(input int i);
        case (i)
            0:       return "R3";
            1, 3:    return "R5";
            5:       return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: dto_flag=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic pump(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            card_clk_en = 1'b1;
            step();
            card_clk_en = 1'b0;
            repeat (gap) step();
        end
    endtask

    task automatic write_ctrl(input logic [31:0] w);
        ctrl_wr = 1'b1;
        ctrl_wdata = w;
        step();
        ctrl_wr = 1'b0;
        ctrl_wdata = '0;
    endtask

    task automatic fresh();
        data_phase = 1'b0;
        step();
        dto_clr = 1'b1;
        step();
        dto_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        check("R1", dto_flag, 1'b0);

        // R1: default code 14 gives 2^15 strobes
        data_phase = 1'b1;
        pump(32767, 0);
        check("R1", dto_flag, 1'b0);
        pump(1, 0);
        check("R1", dto_flag, 1'b1);

        // Table walk: R2, R3, R4, R5
        for (int i = 0; i < NV; i++) begin
            fresh();
            write_ctrl(VEC_WORD[i]);
            data_phase = 1'b1;
            pump(VEC_LIM[i] - 1, VEC_GAP[i]);
            check(vec_req(i), dto_flag, 1'b0);
            pump(1, VEC_GAP[i]);
            check(vec_req(i), dto_flag, 1'b1);
        end

        // R5: no strobes, no progress
        fresh();
        write_ctrl(32'h0000_0000);
        data_phase = 1'b1;
        repeat (20) step();
        check("R5", dto_flag, 1'b0);

        // R6: activity with a strobe restarts the count
        fresh();
        write_ctrl(32'h0001_0000);
        data_phase = 1'b1;
        pump(3, 0);
        card_clk_en = 1'b1;
        data_activity = 1'b1;
        step();
        card_clk_en = 1'b0;
        data_activity = 1'b0;
        pump(3, 0);
        check("R6", dto_flag, 1'b0);
        pump(1, 0);
        check("R6", dto_flag, 1'b1);

        // R7: no flag outside a phase
        fresh();
        write_ctrl(32'h0000_0000);
        pump(10, 0);
        check("R7", dto_flag, 1'b0);

        // R7: a new phase restarts from zero
        write_ctrl(32'h0001_0000);
        data_phase = 1'b1;
        pump(3, 0);
        data_phase = 1'b0;
        step();
        data_phase = 1'b1;
        pump(3, 0);
        check("R7", dto_flag, 1'b0);
        pump(1, 0);
        check("R7", dto_flag, 1'b1);

        // R8: sticky, then cleared
        data_phase = 1'b0;
        repeat (5) step();
        check("R8", dto_flag, 1'b1);
        dto_clr = 1'b1;
        step();
        dto_clr = 1'b0;
        check("R8", dto_flag, 1'b0);

        // R9: expiry and clear together leave the flag set
        fresh();
        write_ctrl(32'h0000_0000);
        data_phase = 1'b1;
        pump(1, 0);
        check("R9", dto_flag, 1'b0);
        card_clk_en = 1'b1;
        dto_clr = 1'b1;
        step();
        card_clk_en = 1'b0;
        dto_clr = 1'b0;
        check("R9", dto_flag, 1'b1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule